// File: doc/BRIEF.md
# Decode-Stage Direct Branch Target Checker

This block sits beside the decode output path. Every cycle it receives a group of up to `W` instructions from fetch, listed in slot order, oldest in slot 0. For each instruction it receives the thread, the sequence number, the class bits, the predicted target and a target that was already computed upstream. It forwards the group one cycle later. While it does so, it compares the predicted target with the computed target for every forwarded instruction that is both a direct control transfer and an unconditional one.

When the first such comparison in slot order fails, the block does four things one cycle later. It sends a redirect to fetch. It marks the younger entries of the same thread in the group as squashed. It stops forwarding any slot after the offending branch. It forwards the branch itself with its target replaced by the correct one. The redirect carries the branch's sequence number as the last good instruction, the correct next PC, and the taken flag. It also carries a flush strobe for the thread, and an unblock strobe when that thread was stalled. Two counters record the branches checked and the mispredictions found.

Top module: `early_redirect_check`

## Requirements
- R1: While `rst` is high at a clock edge, every registered output and both counters become zero.
- R2: A slot with `in_valid` set and `in_sqd` clear, and with no mismatching branch before it in the group, appears in `fwd_valid` one cycle later. A slot with `in_sqd` set is never forwarded. `fwd_tid` and `fwd_seq` are the group's thread and sequence fields, delayed by one cycle.
- R3: Each forwarded slot with `in_ctrl`, `in_direct` and `in_uncond` all set adds one to `cnt_resolved`.
- R4: When such a slot's `in_calc_pc` differs from its `in_pred_pc`, the following happens one cycle later. `cnt_mispred` rises by one. `rd_valid`, `rd_mispred`, `rd_badpred` and `rd_squash` are all 1. `rd_seq` is the branch's sequence number, `rd_pc` is its computed target, and `rd_taken` is its `in_calc_taken`.
- R5: The mismatching branch is still forwarded, with its `fwd_pc` field set to the computed target. No slot after it is forwarded. Every other `fwd_pc` field equals the predicted target.
- R6: On a redirect, `sq_mark[i]` is set for each valid slot whose thread matches the branch's thread and whose sequence number is younger. Younger means that (seq_i − seq_branch) mod 2^SW is nonzero and below 2^(SW−1).
- R7: When several slots mismatch, only the lowest-numbered one is acted upon. Later slots are neither counted as resolved nor as mispredicted.
- R8: A branch with matching targets, and any control transfer that is conditional or indirect, causes no redirect and leaves `cnt_mispred` unchanged.
- R9: On a redirect, `rd_flush` is one-hot with bit tid of the branch's thread. `rd_unblock` carries the same bit only if `thr_stalled[tid]` was 1. Otherwise it is zero.
- R10: `fatal` is set one cycle after a forwarded slot has `in_pred_taken` set and `in_ctrl` clear.
- R11: Redirect outputs last one cycle per event. They are zero in the cycle after a group with no mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | W | Slot holds an instruction |
| in_tid | input | W*TW | Thread id per slot |
| in_seq | input | W*SW | Sequence number per slot |
| in_sqd | input | W | Slot already squashed upstream |
| in_ctrl | input | W | Slot is a control transfer |
| in_direct | input | W | Target is PC-relative |
| in_uncond | input | W | Transfer is unconditional |
| in_pred_taken | input | W | Fetch predicted taken |
| in_pred_pc | input | W*PW | Predicted target per slot |
| in_calc_pc | input | W*PW | Computed target per slot |
| in_calc_taken | input | W | Computed taken flag per slot |
| thr_stalled | input | NT | Thread is blocked or unblocking |
| fwd_valid | output | W | Slots passed on |
| fwd_tid | output | W*TW | Thread ids, delayed |
| fwd_seq | output | W*SW | Sequence numbers, delayed |
| fwd_pc | output | W*PW | Targets, corrected at the redirecting slot |
| sq_mark | output | W | Slots squashed by the redirect |
| rd_valid | output | 1 | Redirect present |
| rd_mispred | output | 1 | Branch mispredict flag |
| rd_badpred | output | 1 | Prediction incorrect flag |
| rd_squash | output | 1 | Squash flag |
| rd_seq | output | SW | Last good sequence number |
| rd_pc | output | PW | Correct next PC |
| rd_taken | output | 1 | Branch taken flag |
| rd_unblock | output | NT | Unblock strobe per thread |
| rd_flush | output | NT | Pending-queue clear strobe per thread |
| fatal | output | 1 | Non-control instruction predicted taken |
| cnt_resolved | output | CW | Direct unconditional branches checked |
| cnt_mispred | output | CW | Mispredictions found |

## Verification
The bench drives the following groups:
- Groups with no branches and with an upstream-squashed slot, to separate plain forwarding from the skip rule.
- Matching direct unconditional branches, which should count but not redirect.
- A mismatching conditional branch, which should be ignored.
- A mismatch in the middle of a mixed-thread group, which exposes the cut-off, the target correction, the per-thread marking and the unblock strobe.
- A group with two mismatches, which shows that only the first is acted upon.
- A group whose sequence numbers wrap past zero, with one entry exactly half the range away, which tests the age comparison at its edge.
- A long run of random groups, which compares all outputs against an independent model.

// File: rtl/early_redirect_check.sv
module early_redirect_check #(
  parameter int W  = 4,
  parameter int TW = 1,
  parameter int SW = 8,
  parameter int PW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    in_valid,
  input  logic [W*TW-1:0] in_tid,
  input  logic [W*SW-1:0] in_seq,
  input  logic [W-1:0]    in_sqd,
  input  logic [W-1:0]    in_ctrl,
  input  logic [W-1:0]    in_direct,
  input  logic [W-1:0]    in_uncond,
  input  logic [W-1:0]    in_pred_taken,
  input  logic [W*PW-1:0] in_pred_pc,
  input  logic [W*PW-1:0] in_calc_pc,
  input  logic [W-1:0]    in_calc_taken,
  input  logic [(1<<TW)-1:0] thr_stalled,
  output logic [W-1:0]    fwd_valid,
  output logic [W*TW-1:0] fwd_tid,
  output logic [W*SW-1:0] fwd_seq,
  output logic [W*PW-1:0] fwd_pc,
  output logic [W-1:0]    sq_mark,
  output logic            rd_valid,
  output logic            rd_mispred,
  output logic            rd_badpred,
  output logic            rd_squash,
  output logic [SW-1:0]   rd_seq,
  output logic [PW-1:0]   rd_pc,
  output logic            rd_taken,
  output logic [(1<<TW)-1:0] rd_unblock,
  output logic [(1<<TW)-1:0] rd_flush,
  output logic            fatal,
  output logic [CW-1:0]   cnt_resolved,
  output logic [CW-1:0]   cnt_mispred
);
  localparam int NT = 1 << TW;
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic            hit;
  logic [IW-1:0]   hidx;
  logic [W-1:0]    fwd_n, chk, sq_n;
  logic [W*PW-1:0] pc_n;
  logic            fat_n;
  logic [CW-1:0]   nres;
  logic [SW-1:0]   b_seq;
  logic [TW-1:0]   b_tid;
  logic [PW-1:0]   b_pc;
  logic            b_tk;

  // slot scan in age order; the first mismatch cuts the group
  always_comb begin
    hit   = 1'b0;
    hidx  = '0;
    fwd_n = '0;
    chk   = '0;
    fat_n = 1'b0;
    pc_n  = in_pred_pc;
    for (int i = 0; i < W; i++) begin
      if (in_valid[i] && !in_sqd[i] && !hit) begin
        fwd_n[i] = 1'b1;
        if (in_pred_taken[i] && !in_ctrl[i]) fat_n = 1'b1;
        if (in_ctrl[i] && in_direct[i] && in_uncond[i]) begin
          chk[i] = 1'b1;
          if (in_calc_pc[i*PW +: PW] != in_pred_pc[i*PW +: PW]) begin
            hit  = 1'b1;
            hidx = IW'(i);
            pc_n[i*PW +: PW] = in_calc_pc[i*PW +: PW];
          end
        end
      end
    end
  end

  assign b_seq = in_seq[hidx*SW +: SW];
  assign b_tid = in_tid[hidx*TW +: TW];
  assign b_pc  = in_calc_pc[hidx*PW +: PW];
  assign b_tk  = in_calc_taken[hidx];

  // wraparound-safe age test against the redirecting branch
  always_comb begin
    sq_n = '0;
    for (int i = 0; i < W; i++) begin
      logic [SW-1:0] d;
      d = in_seq[i*SW +: SW] - b_seq;
      sq_n[i] = hit && in_valid[i] && (in_tid[i*TW +: TW] == b_tid) &&
                (d != '0) && !d[SW-1];
    end
  end

  always_comb begin
    nres = '0;
    for (int i = 0; i < W; i++) nres = nres + {{(CW-1){1'b0}}, chk[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid    <= '0;
      fwd_tid      <= '0;
      fwd_seq      <= '0;
      fwd_pc       <= '0;
      sq_mark      <= '0;
      rd_valid     <= 1'b0;
      rd_seq       <= '0;
      rd_pc        <= '0;
      rd_taken     <= 1'b0;
      rd_unblock   <= '0;
      rd_flush     <= '0;
      fatal        <= 1'b0;
      cnt_resolved <= '0;
      cnt_mispred  <= '0;
    end else begin
      fwd_valid    <= fwd_n;
      fwd_tid      <= in_tid;
      fwd_seq      <= in_seq;
      fwd_pc       <= pc_n;
      sq_mark      <= sq_n;
      rd_valid     <= hit;
      rd_seq       <= hit ? b_seq : '0;
      rd_pc        <= hit ? b_pc : '0;
      rd_taken     <= hit & b_tk;
      rd_flush     <= hit ? (NT'(1) << b_tid) : '0;
      rd_unblock   <= (hit && thr_stalled[b_tid]) ? (NT'(1) << b_tid) : '0;
      fatal        <= fat_n;
      cnt_resolved <= cnt_resolved + nres;
      cnt_mispred  <= cnt_mispred + {{(CW-1){1'b0}}, hit};
    end
  end

  assign rd_mispred = rd_valid;
  assign rd_badpred = rd_valid;
  assign rd_squash  = rd_valid;

  p_resolve_with_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> cnt_resolved != $past(cnt_resolved));

  p_mispred_step_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> cnt_mispred == $past(cnt_mispred) + {{(CW-1){1'b0}}, 1'b1});

  p_no_mispred_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(cnt_mispred));

  p_cut_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (fwd_valid & sq_mark) == '0);

  p_mark_needs_redirect_r6: assert property (@(posedge clk) disable iff (rst)
    (|sq_mark) |-> rd_valid);

  p_unblock_in_flush_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_flush) && ((rd_unblock & ~rd_flush) == '0));
endmodule

// File: tb/tb_early_redirect_check.sv
module tb_early_redirect_check;
  localparam int W = 4, TW = 1, SW = 8, PW = 16, CW = 16, NT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0]    in_valid, in_sqd, in_ctrl, in_direct, in_uncond, in_pred_taken, in_calc_taken;
  logic [W*TW-1:0] in_tid;
  logic [W*SW-1:0] in_seq;
  logic [W*PW-1:0] in_pred_pc, in_calc_pc;
  logic [NT-1:0]   thr_stalled;
  logic [W-1:0]    fwd_valid, sq_mark;
  logic [W*TW-1:0] fwd_tid;
  logic [W*SW-1:0] fwd_seq;
  logic [W*PW-1:0] fwd_pc;
  logic rd_valid, rd_mispred, rd_badpred, rd_squash, rd_taken, fatal;
  logic [SW-1:0] rd_seq;
  logic [PW-1:0] rd_pc;
  logic [NT-1:0] rd_unblock, rd_flush;
  logic [CW-1:0] cnt_resolved, cnt_mispred;

  early_redirect_check #(.W(W), .TW(TW), .SW(SW), .PW(PW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq),
    .in_sqd(in_sqd), .in_ctrl(in_ctrl), .in_direct(in_direct), .in_uncond(in_uncond),
    .in_pred_taken(in_pred_taken), .in_pred_pc(in_pred_pc), .in_calc_pc(in_calc_pc),
    .in_calc_taken(in_calc_taken), .thr_stalled(thr_stalled), .fwd_valid(fwd_valid),
    .fwd_tid(fwd_tid), .fwd_seq(fwd_seq), .fwd_pc(fwd_pc), .sq_mark(sq_mark),
    .rd_valid(rd_valid), .rd_mispred(rd_mispred), .rd_badpred(rd_badpred),
    .rd_squash(rd_squash), .rd_seq(rd_seq), .rd_pc(rd_pc), .rd_taken(rd_taken),
    .rd_unblock(rd_unblock), .rd_flush(rd_flush), .fatal(fatal),
    .cnt_resolved(cnt_resolved), .cnt_mispred(cnt_mispred));

  typedef struct {
    string         tag;
    logic [W-1:0]  fv, sq;
    logic [W*TW-1:0] ft;
    logic [W*SW-1:0] fs;
    logic [W*PW-1:0] fp;
    logic          rv, rt, fat;
    logic [SW-1:0] rs;
    logic [PW-1:0] rp;
    logic [NT-1:0] ub, fl;
    logic [CW-1:0] cres, cmis;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [CW-1:0] m_res = '0, m_mis = '0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_group();
    in_valid = '0; in_sqd = '0; in_ctrl = '0; in_direct = '0; in_uncond = '0;
    in_pred_taken = '0; in_calc_taken = '0; in_tid = '0; in_seq = '0;
    in_pred_pc = '0; in_calc_pc = '0; thr_stalled = '0;
  endtask

  task automatic set_slot(int i, int tid, int seq, bit c, bit d, bit u, bit pt, bit sqd,
                          int pp, int cp, bit ct);
    in_valid[i] = 1'b1; in_tid[i*TW +: TW] = TW'(tid); in_seq[i*SW +: SW] = SW'(seq);
    in_ctrl[i] = c; in_direct[i] = d; in_uncond[i] = u; in_pred_taken[i] = pt;
    in_sqd[i] = sqd; in_pred_pc[i*PW +: PW] = PW'(pp); in_calc_pc[i*PW +: PW] = PW'(cp);
    in_calc_taken[i] = ct;
  endtask

  // independent model of the requirements; pushes the result for the next cycle
  task automatic send(string tag);
    exp_t e;
    bit hit = 0;
    int hb = 0;
    e.tag = tag; e.fv = '0; e.sq = '0; e.fat = 0; e.fp = in_pred_pc;
    e.ft = in_tid; e.fs = in_seq;
    for (int i = 0; i < W; i++) begin
      if (in_valid[i] && !in_sqd[i] && !hit) begin
        e.fv[i] = 1'b1;
        if (in_pred_taken[i] && !in_ctrl[i]) e.fat = 1;
        if (in_ctrl[i] && in_direct[i] && in_uncond[i]) begin
          m_res = m_res + 1'b1;
          if (in_calc_pc[i*PW +: PW] != in_pred_pc[i*PW +: PW]) begin
            hit = 1; hb = i;
            e.fp[i*PW +: PW] = in_calc_pc[i*PW +: PW];
          end
        end
      end
    end
    e.rv = hit; e.rs = '0; e.rp = '0; e.rt = 0; e.ub = '0; e.fl = '0;
    if (hit) begin
      logic [SW-1:0] bs;
      logic [TW-1:0] bt;
      m_mis = m_mis + 1'b1;
      bs = in_seq[hb*SW +: SW]; bt = in_tid[hb*TW +: TW];
      e.rs = bs; e.rp = in_calc_pc[hb*PW +: PW]; e.rt = in_calc_taken[hb];
      e.fl = NT'(1) << bt;
      if (thr_stalled[bt]) e.ub = NT'(1) << bt;
      for (int i = 0; i < W; i++) begin
        logic [SW-1:0] d;
        d = in_seq[i*SW +: SW] - bs;
        if (in_valid[i] && in_tid[i*TW +: TW] == bt && d != 0 && d < (1 << (SW-1)))
          e.sq[i] = 1'b1;
      end
    end
    e.cres = m_res; e.cmis = m_mis;
    q.push_back(e);
  endtask

  // monitor: compares the registered outputs after each edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R2", {e.tag, " fwd_valid"}, 64'(fwd_valid), 64'(e.fv));
      check("R2", {e.tag, " fwd_tid"}, 64'(fwd_tid), 64'(e.ft));
      check("R2", {e.tag, " fwd_seq"}, 64'(fwd_seq), 64'(e.fs));
      check("R5", {e.tag, " fwd_pc"}, 64'(fwd_pc), 64'(e.fp));
      check("R6", {e.tag, " sq_mark"}, 64'(sq_mark), 64'(e.sq));
      check("R4", {e.tag, " rd_valid"}, 64'(rd_valid), 64'(e.rv));
      check("R4", {e.tag, " flags"}, 64'({rd_mispred, rd_badpred, rd_squash}), 64'({3{e.rv}}));
      check("R4", {e.tag, " rd_seq"}, 64'(rd_seq), 64'(e.rs));
      check("R4", {e.tag, " rd_pc"}, 64'(rd_pc), 64'(e.rp));
      check("R4", {e.tag, " rd_taken"}, 64'(rd_taken), 64'(e.rt));
      check("R9", {e.tag, " rd_unblock"}, 64'(rd_unblock), 64'(e.ub));
      check("R9", {e.tag, " rd_flush"}, 64'(rd_flush), 64'(e.fl));
      check("R10", {e.tag, " fatal"}, 64'(fatal), 64'(e.fat));
      check("R3", {e.tag, " cnt_resolved"}, 64'(cnt_resolved), 64'(e.cres));
      check("R4", {e.tag, " cnt_mispred"}, 64'(cnt_mispred), 64'(e.cmis));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_group();
    in_valid = '1; in_pred_taken = '1;
    in_calc_pc = '1;
    in_ctrl = '1; in_direct = '1; in_uncond = '1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset clears everything even with an active mismatching group
    check("R1", "fwd_valid", 64'(fwd_valid), 64'h0);
    check("R1", "redirect", 64'({rd_valid, rd_unblock, rd_flush, fatal}), 64'h0);
    check("R1", "counters", 64'({cnt_resolved, cnt_mispred}), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // R2: plain forwarding, slot 2 already squashed upstream
    clear_group();
    set_slot(0, 0, 1, 0,0,0,0,0, 16'h10, 16'h10, 0);
    set_slot(1, 1, 2, 0,0,0,0,0, 16'h20, 16'h20, 0);
    set_slot(2, 0, 3, 0,0,0,0,1, 16'h30, 16'h30, 0);
    set_slot(3, 0, 4, 0,0,0,0,0, 16'h40, 16'h40, 0);
    send("plain");
    @(negedge clk);

    // R3 R8: two matching direct unconditional branches, no redirect
    clear_group();
    set_slot(0, 0, 5, 1,1,1,1,0, 16'h100, 16'h100, 1);
    set_slot(1, 0, 6, 1,1,1,1,0, 16'h200, 16'h200, 1);
    set_slot(2, 1, 7, 0,0,0,0,0, 16'h0, 16'h0, 0);
    send("match");
    @(negedge clk);

    // R8: conditional and indirect mismatches are not checked
    clear_group();
    set_slot(0, 0, 8, 1,1,0,1,0, 16'h300, 16'h304, 1);
    set_slot(1, 0, 9, 1,0,1,1,0, 16'h400, 16'h408, 1);
    send("cond_indirect");
    @(negedge clk);

    // R4 R5 R6 R9: mismatch at slot 1, thread 0 stalled
    clear_group();
    set_slot(0, 1, 9,  0,0,0,0,0, 16'h11, 16'h11, 0);
    set_slot(1, 0, 10, 1,1,1,1,0, 16'h500, 16'h540, 1);
    set_slot(2, 0, 11, 0,0,0,0,0, 16'h22, 16'h22, 0);
    set_slot(3, 1, 12, 0,0,0,0,0, 16'h33, 16'h33, 0);
    thr_stalled = 2'b01;
    send("mid_mismatch");
    @(negedge clk);

    // R11: the redirect does not persist into an empty cycle
    clear_group();
    send("idle_after");
    @(negedge clk);

    // R7: two mismatches, only slot 0 acts; the second is neither resolved nor counted
    clear_group();
    set_slot(0, 1, 20, 1,1,1,1,0, 16'h600, 16'h610, 0);
    set_slot(1, 0, 21, 0,0,0,0,0, 16'h0, 16'h0, 0);
    set_slot(2, 1, 22, 1,1,1,1,0, 16'h700, 16'h710, 1);
    thr_stalled = 2'b01;
    send("two_mismatch");
    @(negedge clk);

    // R6: wraparound ages; slot 3 is exactly half the range away and not younger
    clear_group();
    set_slot(0, 1, 254, 1,1,1,1,0, 16'h800, 16'h820, 1);
    set_slot(1, 1, 255, 0,0,0,0,0, 0, 0, 0);
    set_slot(2, 1, 0,   0,0,0,0,0, 0, 0, 0);
    set_slot(3, 1, 126, 0,0,0,0,0, 0, 0, 0);
    thr_stalled = 2'b10;
    send("wrap");
    @(negedge clk);

    // R10: non-control predicted taken
    clear_group();
    set_slot(0, 0, 30, 0,0,0,1,0, 16'h1, 16'h1, 0);
    send("fatal");
    @(negedge clk);

    // R2..R11 under random groups
    for (int n = 0; n < 200; n++) begin
      clear_group();
      for (int i = 0; i < W; i++) begin
        int pp;
        pp = int'($urandom_range(0, 3));
        set_slot(i, int'($urandom_range(0, 1)), (n * W + i) % 256,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 7) == 0, pp,
                 ($urandom_range(0, 2) == 0) ? pp + 4 : pp, $urandom_range(0, 1) == 1);
        if ($urandom_range(0, 7) == 0) in_valid[i] = 1'b0;
      end
      thr_stalled = NT'($urandom_range(0, 3));
      send("random");
      @(negedge clk);
    end

    clear_group();
    send("final_idle");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule